// File: doc/BRIEF.md
# Big-endian load data aligner

This block sits at the back end of a load path. It receives the effective address of a load, the naturally aligned memory word that holds the addressed data, and a 3-bit code for the kind of load. It picks the addressed byte, halfword or word out of that word using big-endian lane numbering, so the lowest address maps to the most significant bits. It then sign- or zero-extends the result to 32 bits and hands it to the register file with a write enable.

Halfword and word loads must be naturally aligned. A misaligned one raises an address-error flag and suppresses the register write. Byte loads can never be misaligned. All results are registered, and a valid strobe marks each result one clock after the request. The memory bus width is a parameter: a multiple of 32 bits, with big-endian lane numbering across the whole bus.

Top module: `ld_align`

## Requirements
- R1: For a signed byte load (code 0) or unsigned byte load (code 1), address offset 0 takes bits 31:24 of the memory word, offset 1 takes bits 23:16, offset 2 takes bits 15:8 and offset 3 takes bits 7:0.
- R2: For a signed halfword load (code 2) or unsigned halfword load (code 3), address bit 1 clear takes bits 31:16 and address bit 1 set takes bits 15:0.
- R3: Code 0 copies bit 7 of the chosen byte into result bits 31:8. Code 1 clears result bits 31:8.
- R4: Code 2 copies bit 15 of the chosen halfword into result bits 31:16. Code 3 clears result bits 31:16.
- R5: A halfword load (code 2 or 3) with address bit 0 set raises the address-error flag and leaves the write enable low.
- R6: A word load (code 4) whose two low address bits are not both zero raises the address-error flag and leaves the write enable low. An aligned word load writes the whole memory word unchanged.
- R7: Byte loads (codes 0 and 1) never raise the address-error flag, whatever the address.
- R8: The valid strobe, write enable, error flag and result are registered. The valid output equals the request valid of the previous cycle. Write enable and error flag are both low in any cycle where the valid output is low.
- R9: Codes 5, 6 and 7 still produce a valid strobe, but with the write enable low and the error flag low.
- R10: The result bus reads all zeros whenever the write enable is low.
- R11: While reset is asserted (active low), all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A load request is present this cycle |
| eff_addr | input | 32 | Effective byte address of the load |
| rd_word | input | 32 | Aligned memory word containing the addressed data |
| ld_kind | input | 3 | Load code: 0 signed byte, 1 unsigned byte, 2 signed half, 3 unsigned half, 4 word |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| wr_data | output | 32 | Extended value for the destination register |
| wr_en | output | 1 | Register write enable |
| addr_fault | output | 1 | Misaligned halfword or word access |

## Verification
The bench walks a byte load over all four offsets, using a word whose bytes all differ and carry different top bits. A design with little-endian lane order, or one that extends from the wrong bit, returns a visibly wrong value. Halfword and word loads are applied at every low-address combination, so a check that looks at the wrong address bit either misses a fault or flags an aligned access. Byte loads go to odd addresses with high address bits set, which catches a design that applies alignment checks to bytes. Back-to-back requests, idle cycles and the unused codes expose a lost valid strobe, stale data left on the result bus, or a spurious write or fault.

// File: rtl/ld_align_pkg.sv
package ld_align_pkg;

   typedef enum logic [2:0] {
      LK_BYTE_S = 3'd0,
      LK_BYTE_U = 3'd1,
      LK_HALF_S = 3'd2,
      LK_HALF_U = 3'd3,
      LK_WORD   = 3'd4
   } ld_kind_e;

   typedef enum logic [1:0] {
      SZ_NONE = 2'd0,
      SZ_BYTE = 2'd1,
      SZ_HALF = 2'd2,
      SZ_WORD = 2'd3
   } ld_size_e;

   localparam int WORD_W = 32;
   localparam int HALF_W = 16;
   localparam int BYTE_W = 8;

endpackage

// File: rtl/ld_align_lane_pick.sv
module ld_align_lane_pick #(
   parameter int DATA_W = 32,
   parameter int LANE_W = 8,
   parameter int OFF_W  = 2
) (
   input  logic [DATA_W-1:0] bus,
   input  logic [OFF_W-1:0]  off,
   output logic [LANE_W-1:0] lane
);
   localparam int LANES = DATA_W / LANE_W;
   localparam int SHIFT = $clog2(LANE_W / 8);

   if (DATA_W % LANE_W != 0) begin : g_bad_lane
      $error("lane width must divide the bus width");
   end

   if (LANES == 1) begin : g_single
      logic [OFF_W-1:0] unused_off;
      assign unused_off = off;
      assign lane = bus;
   end else begin : g_multi
      logic [OFF_W-1:0] idx;
      assign idx = off >> SHIFT;
      always_comb begin
         lane = '0;
         for (int i = 0; i < LANES; i++) begin
            // lane 0 sits at the most significant end (big-endian)
            if (idx == i[OFF_W-1:0]) lane = bus[DATA_W-1-i*LANE_W -: LANE_W];
         end
      end
   end
endmodule

// File: rtl/ld_align_extend.sv
module ld_align_extend #(
   parameter int IN_W  = 8,
   parameter int OUT_W = 32
) (
   input  logic [IN_W-1:0]  din,
   input  logic             sext,
   output logic [OUT_W-1:0] dout
);
   if (IN_W > OUT_W) begin : g_bad_width
      $error("extender input wider than output");
   end

   if (IN_W == OUT_W) begin : g_pass
      logic unused_sext;
      assign unused_sext = sext;
      assign dout = din;
   end else begin : g_ext
      logic fill;
      assign fill = sext & din[IN_W-1];
      assign dout = {{(OUT_W-IN_W){fill}}, din};
   end
endmodule

// File: rtl/ld_align_decode.sv
module ld_align_decode
   import ld_align_pkg::*;
(
   input  logic [2:0] kind,
   input  logic [1:0] off_lo,
   output ld_size_e   size,
   output logic       sext,
   output logic       fault
);
   always_comb begin
      size  = SZ_NONE;
      sext  = 1'b0;
      fault = 1'b0;
      case (kind)
         LK_BYTE_S: begin size = SZ_BYTE; sext = 1'b1; end
         LK_BYTE_U: size = SZ_BYTE;
         LK_HALF_S: begin size = SZ_HALF; sext = 1'b1; fault = off_lo[0]; end
         LK_HALF_U: begin size = SZ_HALF; fault = off_lo[0]; end
         LK_WORD:   begin size = SZ_WORD; fault = |off_lo; end
         default:   size = SZ_NONE;
      endcase
   end

   always_comb begin
      if (size == SZ_BYTE) assert_byte_no_fault_R7 : assert (!fault);
      if (size == SZ_NONE) assert_unused_no_fault_R9 : assert (!fault);
   end
endmodule

// File: rtl/ld_align.sv
module ld_align
   import ld_align_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [ADDR_W-1:0] eff_addr,
   input  logic [DATA_W-1:0] rd_word,
   input  logic [2:0]        ld_kind,
   output logic              out_valid,
   output logic [WORD_W-1:0] wr_data,
   output logic              wr_en,
   output logic              addr_fault
);
   localparam int OFF_W = $clog2(DATA_W / 8);

   if (DATA_W % WORD_W != 0 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_bus
      $error("bus width must be a power of two and a multiple of 32");
   end
   if (ADDR_W <= OFF_W) begin : g_bad_addr
      $error("address narrower than the lane offset");
   end

   logic [OFF_W-1:0] off;
   logic             unused_addr_hi;
   assign off            = eff_addr[OFF_W-1:0];
   assign unused_addr_hi = ^eff_addr[ADDR_W-1:OFF_W];

   ld_size_e size;
   logic     sext, fault;

   ld_align_decode u_decode (
      .kind   (ld_kind),
      .off_lo (off[1:0]),
      .size   (size),
      .sext   (sext),
      .fault  (fault)
   );

   logic [BYTE_W-1:0] byte_lane;
   logic [HALF_W-1:0] half_lane;
   logic [WORD_W-1:0] word_lane;

   ld_align_lane_pick #(.DATA_W(DATA_W), .LANE_W(BYTE_W), .OFF_W(OFF_W)) u_pick_b (
      .bus (rd_word), .off (off), .lane (byte_lane));
   ld_align_lane_pick #(.DATA_W(DATA_W), .LANE_W(HALF_W), .OFF_W(OFF_W)) u_pick_h (
      .bus (rd_word), .off (off), .lane (half_lane));
   ld_align_lane_pick #(.DATA_W(DATA_W), .LANE_W(WORD_W), .OFF_W(OFF_W)) u_pick_w (
      .bus (rd_word), .off (off), .lane (word_lane));

   logic [WORD_W-1:0] byte_ext, half_ext, word_ext;

   ld_align_extend #(.IN_W(BYTE_W), .OUT_W(WORD_W)) u_ext_b (
      .din (byte_lane), .sext (sext), .dout (byte_ext));
   ld_align_extend #(.IN_W(HALF_W), .OUT_W(WORD_W)) u_ext_h (
      .din (half_lane), .sext (sext), .dout (half_ext));
   ld_align_extend #(.IN_W(WORD_W), .OUT_W(WORD_W)) u_ext_w (
      .din (word_lane), .sext (sext), .dout (word_ext));

   logic [WORD_W-1:0] value;
   logic              do_write;

   always_comb begin
      case (size)
         SZ_BYTE: value = byte_ext;
         SZ_HALF: value = half_ext;
         SZ_WORD: value = word_ext;
         default: value = '0;
      endcase
   end

   assign do_write = in_valid && (size != SZ_NONE) && !fault;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         wr_en      <= 1'b0;
         addr_fault <= 1'b0;
         wr_data    <= '0;
      end else begin
         out_valid  <= in_valid;
         wr_en      <= do_write;
         addr_fault <= in_valid && fault;
         wr_data    <= do_write ? value : '0;
      end
   end

   // R8: strobe follows the request by exactly one cycle
   assert_valid_follows_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   assert_idle_quiet_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && !wr_en && !addr_fault));
   // R5/R6: a fault never writes
   assert_fault_blocks_write_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      addr_fault |-> !wr_en);
   // R10: result bus is clean when nothing is written
   assert_quiet_data_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |-> (wr_data == '0));
   // R3: unsigned byte loads clear the upper bits
   assert_ubyte_zero_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && ld_kind == LK_BYTE_U) |=> (wr_data[WORD_W-1:BYTE_W] == '0));
   // R4: unsigned halfword loads clear the upper bits
   assert_uhalf_zero_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && ld_kind == LK_HALF_U) |=> (wr_data[WORD_W-1:HALF_W] == '0));
   // R7: byte loads never fault
   assert_byte_clean_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (ld_kind == LK_BYTE_S || ld_kind == LK_BYTE_U)) |=> (wr_en && !addr_fault));
   // R9: unused codes neither write nor fault
   assert_unused_code_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && ld_kind > 3'd4) |=> (out_valid && !wr_en && !addr_fault));
endmodule

// File: tb/ld_align_bench.sv
`timescale 1ns/1ps
module ld_align_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] eff_addr = '0;
   logic [31:0] rd_word = '0;
   logic [2:0]  ld_kind = '0;
   logic        out_valid, wr_en, addr_fault;
   logic [31:0] wr_data;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   ld_align u_ld_align (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .eff_addr(eff_addr),
      .rd_word(rd_word), .ld_kind(ld_kind), .out_valid(out_valid),
      .wr_data(wr_data), .wr_en(wr_en), .addr_fault(addr_fault));

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   // independent reference: {write, fault, data}
   function automatic logic [33:0] ref_load(input logic [31:0] a, input logic [31:0] w,
                                            input logic [2:0] k);
      logic [7:0]  b;
      logic [15:0] h;
      case (k)
         3'd0, 3'd1: begin
            case (a[1:0])
               2'd0: b = w[31:24];
               2'd1: b = w[23:16];
               2'd2: b = w[15:8];
               default: b = w[7:0];
            endcase
            if (k == 3'd0 && b[7]) return {2'b10, 24'hFFFFFF, b};
            return {2'b10, 24'h0, b};
         end
         3'd2, 3'd3: begin
            if (a[0]) return {2'b01, 32'h0};
            h = a[1] ? w[15:0] : w[31:16];
            if (k == 3'd2 && h[15]) return {2'b10, 16'hFFFF, h};
            return {2'b10, 16'h0, h};
         end
         3'd4: begin
            if (a[1:0] != 2'd0) return {2'b01, 32'h0};
            return {2'b10, w};
         end
         default: return {2'b00, 32'h0};
      endcase
   endfunction

   task automatic one_load(input string req, input logic [31:0] a, input logic [31:0] w,
                           input logic [2:0] k);
      logic [33:0] e;
      e = ref_load(a, w, k);
      @(negedge clk);
      in_valid = 1'b1; eff_addr = a; rd_word = w; ld_kind = k;
      @(negedge clk);
      in_valid = 1'b0;
      check({req, " valid"}, {31'd0, out_valid}, 32'd1);
      check({req, " wr_en"}, {31'd0, wr_en}, {31'd0, e[33]});
      check({req, " fault"}, {31'd0, addr_fault}, {31'd0, e[32]});
      check({req, " data"}, wr_data, e[31:0]);
   endtask

   task automatic test_reset();
      check("R11 valid", {31'd0, out_valid}, 32'd0);
      check("R11 wr_en", {31'd0, wr_en}, 32'd0);
      check("R11 fault", {31'd0, addr_fault}, 32'd0);
      check("R11 data", wr_data, 32'd0);
   endtask

   task automatic test_bytes();
      for (int o = 0; o < 4; o++) begin
         one_load("R1 R3 sbyte", 32'h1000_0000 + o, 32'h807F_C301, 3'd0);
         one_load("R1 R3 ubyte", 32'h2000_0000 + o, 32'h807F_C301, 3'd1);
      end
      for (int o = 0; o < 4; o++)
         one_load("R1 lanes", 32'h0000_0040 + o, 32'h1122_3344, 3'd1);
   endtask

   task automatic test_halves();
      one_load("R2 R4 shalf hi", 32'h0000_0100, 32'h8001_7FFE, 3'd2);
      one_load("R2 R4 shalf lo", 32'h0000_0102, 32'h8001_7FFE, 3'd2);
      one_load("R2 R4 uhalf hi", 32'h0000_0100, 32'h8001_7FFE, 3'd3);
      one_load("R2 R4 uhalf lo", 32'h0000_0102, 32'h7001_9FFE, 3'd3);
      one_load("R2 R4 shalf lo neg", 32'h0000_0106, 32'h1234_F00D, 3'd2);
   endtask

   task automatic test_half_faults();
      one_load("R5 shalf off1", 32'h0000_0201, 32'hDEAD_BEEF, 3'd2);
      one_load("R5 uhalf off3", 32'h0000_0203, 32'hDEAD_BEEF, 3'd3);
   endtask

   task automatic test_words();
      for (int o = 0; o < 4; o++)
         one_load("R6 word", 32'h0000_0300 + o, 32'hCAFE_F00D, 3'd4);
   endtask

   task automatic test_byte_never_faults();
      one_load("R7 sbyte odd", 32'hFFFF_FFFF, 32'hA5A5_5A5A, 3'd0);
      one_load("R7 ubyte odd", 32'h8000_0001, 32'hA5A5_5A5A, 3'd1);
   endtask

   task automatic test_unused_codes();
      for (int k = 5; k < 8; k++)
         one_load("R9 R10 unused", 32'h0000_0400, 32'hFFFF_FFFF, k[2:0]);
   endtask

   task automatic test_stream();
      // back-to-back requests: each result appears one cycle later
      logic [31:0] aq[3] = '{32'h0000_0001, 32'h0000_0002, 32'h0000_0005};
      logic [2:0]  kq[3] = '{3'd0, 3'd3, 3'd4};
      logic [31:0] w = 32'hF1E2_D3C4;
      logic [33:0] e;
      @(negedge clk);
      for (int i = 0; i < 3; i++) begin
         in_valid = 1'b1; eff_addr = aq[i]; rd_word = w; ld_kind = kq[i];
         @(negedge clk);
         e = ref_load(aq[i], w, kq[i]);
         check("R8 stream valid", {31'd0, out_valid}, 32'd1);
         check("R8 stream data", wr_data, e[31:0]);
         check("R8 R10 stream fault", {31'd0, addr_fault}, {31'd0, e[32]});
      end
      in_valid = 1'b0;
      @(negedge clk);
      check("R8 idle valid", {31'd0, out_valid}, 32'd0);
      check("R8 idle wr_en", {31'd0, wr_en}, 32'd0);
      check("R8 R10 idle data", wr_data, 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      test_reset();
      rst_n = 1'b1;
      test_bytes();
      test_halves();
      test_half_faults();
      test_words();
      test_byte_never_faults();
      test_unused_codes();
      test_stream();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         repeat (200000) @(posedge clk);
      join_any
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
      end
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule